// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block is a next-address predictor for an instruction fetch stage. Fetch presents the current program counter and receives, in the same cycle, the address it should fetch next. Because the lookup uses nothing but the PC, the prediction is ready before the instruction word has been decoded.

The table holds 2^IDX_W entries and is direct-mapped. Instructions are word-aligned, so the index is taken from the PC bits just above the two byte-offset bits. Each entry keeps a valid flag, the full PC of a control-transfer instruction and that instruction's target. A lookup hits only when the selected entry is valid and its stored PC equals the lookup PC exactly. On a hit the stored target is returned. On a miss the sequential address pc+4 is returned.

The execute stage trains the table through an update port once a branch or jump has resolved. A taken transfer writes the whole entry. A not-taken branch that currently hits invalidates its entry. Updates for instructions that are not control transfers are ignored.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so each lookup reports predHit=0 and predPc=lookupPc+4.
- R2: When the entry at the lookup index is valid and its stored PC equals lookupPc, predHit=1 and predPc equals the stored target, both in the same cycle that lookupPc is presented.
- R3: On a miss, predPc=lookupPc+4, computed modulo 2^ADDR_W so that 0xFFFFFFFC yields 0x00000000.
- R4: The index is lookupPc[IDX_W+1:2]. PCs that share an index but differ in any other bit, including bits [1:0], do not hit each other's entry. A write to a shared index replaces the previous occupant.
- R5: An update with updEn=1, updIsCtrl=1 and updTaken=1 stores {valid, updPc, updTarget} at index updPc[IDX_W+1:2]. Lookups see the new entry from the following cycle.
- R6: An update with updEn=1, updIsCtrl=1 and updTaken=0 clears the valid bit at its index only if that entry is valid and holds updPc. If the entry holds another PC it is left intact.
- R7: An update with updIsCtrl=0 changes no entry, whatever its other fields hold.
- R8: A lookup in the same cycle as an update to the same index returns the contents the entry had before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset, clears all valid bits |
| lookupPc | input | ADDR_W | PC presented by fetch |
| predPc | output | ADDR_W | Predicted next fetch address |
| predHit | output | 1 | High when predPc came from a valid matching entry |
| updEn | input | 1 | Update request from the resolving stage |
| updIsCtrl | input | 1 | High when the resolved instruction is a branch or jump |
| updTaken | input | 1 | High when the resolved transfer was taken |
| updPc | input | ADDR_W | PC of the resolved instruction |
| updTarget | input | ADDR_W | Resolved target address |

## Verification
Lookup results are combinational, so each expected prediction is due in the same cycle its PC is driven. The bench drives inputs just after a rising edge and the monitor compares at the following falling edge. An update is captured at the next rising edge. A lookup issued in the update's own cycle is therefore scored against the old contents, and the lookup one cycle later against the new ones. The driver queues each expected result with the cycle it belongs to, so the monitor never scores a value one cycle early or late.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Byte-offset bits below the index; instructions are word aligned.
  localparam int OFFSET_BITS = 2;
  localparam int INSN_BYTES  = 1 << OFFSET_BITS;

  // Strobes from control to the table datapath.
  typedef struct packed {
    logic writeEntry;   // store {valid, pc, target}
    logic clearValid;   // drop the valid bit
  } btbStrobe_t;

endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updEn,
  input  logic       updIsCtrl,
  input  logic       updTaken,
  input  logic       updProbeHit,
  output btbStrobe_t strb
);

  logic trainReq;

  // Only resolved control transfers may train the table.
  assign trainReq = updEn && updIsCtrl;

  always_comb begin
    strb = '0;
    if (trainReq) begin
      if (updTaken) begin
        strb.writeEntry = 1'b1;
      end else if (updProbeHit) begin
        strb.clearValid = 1'b1;
      end
    end
  end

  AST_NONCTRL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && !updIsCtrl) |-> (strb == '0)); // R7

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.writeEntry && strb.clearValid)); // R6

  AST_CLEAR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearValid |-> (updProbeHit && !updTaken)); // R6

endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget,
  input  btbStrobe_t        strb,
  output logic [ADDR_W-1:0] predPc,
  output logic              predHit,
  output logic              updProbeHit
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_LO  = OFFSET_BITS;
  localparam int IDX_HI  = OFFSET_BITS + IDX_W - 1;

  logic [ENTRIES-1:0] validVec;
  logic [ADDR_W-1:0]  tagMem [ENTRIES];
  logic [ADDR_W-1:0]  tgtMem [ENTRIES];

  logic [IDX_W-1:0]   lookupIdx;
  logic [IDX_W-1:0]   updIdx;
  logic [ADDR_W-1:0]  seqPc;

  assign lookupIdx = lookupPc[IDX_HI:IDX_LO];
  assign updIdx    = updPc[IDX_HI:IDX_LO];

  // Valid bits: reset to empty, set on write, dropped on clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (updIdx == IDX_W'(e)) begin
          if (strb.writeEntry) begin
            validVec[e] <= 1'b1;
          end else if (strb.clearValid) begin
            validVec[e] <= 1'b0;
          end
        end
      end
    end
  end

  // Stored PC and target need no reset; valid bit guards them.
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (strb.writeEntry && (updIdx == IDX_W'(e))) begin
        tagMem[e] <= updPc;
        tgtMem[e] <= updTarget;
      end
    end
  end

  // Lookup path: pure function of the PC and current contents.
  assign seqPc       = lookupPc + ADDR_W'(INSN_BYTES);
  assign predHit     = validVec[lookupIdx] && (tagMem[lookupIdx] == lookupPc);
  assign predPc      = predHit ? tgtMem[lookupIdx] : seqPc;

  // Update-side probe used to decide whether a not-taken branch clears.
  assign updProbeHit = validVec[updIdx] && (tagMem[updIdx] == updPc);

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEntry |=> (validVec[$past(updIdx)] &&
                         tagMem[$past(updIdx)] == $past(updPc) &&
                         tgtMem[$past(updIdx)] == $past(updTarget))); // R5

  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearValid |=> !validVec[$past(updIdx)]); // R6

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(validVec)); // R7

  AST_MISS_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (predPc == lookupPc + ADDR_W'(4))); // R3

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    predHit |-> validVec[lookupIdx]); // R2

  AST_ONE_ENTRY_CHANGES: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validVec ^ $past(validVec)) <= 1); // R4

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupPc,
  output logic [ADDR_W-1:0] predPc,
  output logic              predHit,
  input  logic              updEn,
  input  logic              updIsCtrl,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ADDR_W-1:0] updTarget
);

  btbStrobe_t strb;
  logic       updProbeHit;

  btb_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .updEn      (updEn),
    .updIsCtrl  (updIsCtrl),
    .updTaken   (updTaken),
    .updProbeHit(updProbeHit),
    .strb       (strb)
  );

  btb_datapath #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .lookupPc   (lookupPc),
    .updPc      (updPc),
    .updTarget  (updTarget),
    .strb       (strb),
    .predPc     (predPc),
    .predHit    (predHit),
    .updProbeHit(updProbeHit)
  );

endmodule

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] lookupPc = '0;
  logic [ADDR_W-1:0] predPc;
  logic              predHit;
  logic              updEn = 1'b0;
  logic              updIsCtrl = 1'b0;
  logic              updTaken = 1'b0;
  logic [ADDR_W-1:0] updPc = '0;
  logic [ADDR_W-1:0] updTarget = '0;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] expPc;
    logic              expHit;
    string             req;
  } expItem_t;

  expItem_t expQ[$];

  // Pending update applied in the cycle of the next lookup.
  logic              pendEn = 1'b0;
  logic              pendCtrl = 1'b0;
  logic              pendTaken = 1'b0;
  logic [ADDR_W-1:0] pendPc = '0;
  logic [ADDR_W-1:0] pendTgt = '0;

  always #2.5 clk = ~clk;

  btb_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predPc(predPc),
    .predHit(predHit), .updEn(updEn), .updIsCtrl(updIsCtrl),
    .updTaken(updTaken), .updPc(updPc), .updTarget(updTarget)
  );

  task automatic setUpd(input logic isCtrl, input logic taken,
                        input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] tgt);
    pendEn = 1'b1; pendCtrl = isCtrl; pendTaken = taken;
    pendPc = pc; pendTgt = tgt;
  endtask

  // Driver: one lookup per cycle, expected result due the same cycle.
  task automatic look(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] expPc,
                      input logic expHit, input string req);
    expItem_t it;
    @(posedge clk); #1;
    lookupPc  = pc;
    updEn     = pendEn;
    updIsCtrl = pendCtrl;
    updTaken  = pendTaken;
    updPc     = pendPc;
    updTarget = pendTgt;
    pendEn    = 1'b0;
    it.pc = pc; it.expPc = expPc; it.expHit = expHit; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compares at the falling edge of the driven cycle.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (predPc !== it.expPc || predHit !== it.expHit) begin
        failures++;
        $display("FAIL %s pc=%h got predPc=%h hit=%b expected predPc=%h hit=%b",
                 it.req, it.pc, predPc, predHit, it.expPc, it.expHit);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired got running expected done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #12 rstN = 1'b1;

    // R1: empty after reset
    look(32'h0000_0100, 32'h0000_0104, 1'b0, "R1");
    look(32'h0000_013C, 32'h0000_0140, 1'b0, "R1");
    // R3: sequential fallback wraps
    look(32'hFFFF_FFFC, 32'h0000_0000, 1'b0, "R3");

    // R5 write; R8 same-cycle lookup sees old contents
    setUpd(1'b1, 1'b1, 32'h0000_0100, 32'h0000_0800);
    look(32'h0000_0100, 32'h0000_0104, 1'b0, "R8");
    look(32'h0000_0100, 32'h0000_0800, 1'b1, "R5");
    look(32'h0000_0100, 32'h0000_0800, 1'b1, "R2");

    // R4: same index, other PC bits differ -> no hit
    look(32'h0000_0140, 32'h0000_0144, 1'b0, "R4");
    look(32'h0000_0102, 32'h0000_0106, 1'b0, "R4");

    // R7: non-control update ignored
    setUpd(1'b0, 1'b1, 32'h0000_0104, 32'h0000_0900);
    look(32'h0000_0200, 32'h0000_0204, 1'b0, "R7");
    look(32'h0000_0104, 32'h0000_0108, 1'b0, "R7");
    setUpd(1'b0, 1'b0, 32'h0000_0100, 32'h0000_0000);
    look(32'h0000_0200, 32'h0000_0204, 1'b0, "R7");
    look(32'h0000_0100, 32'h0000_0800, 1'b1, "R7");

    // R6: not-taken with a different PC at the index leaves entry intact
    setUpd(1'b1, 1'b0, 32'h0000_0140, 32'h0000_0000);
    look(32'h0000_0300, 32'h0000_0304, 1'b0, "R6");
    look(32'h0000_0100, 32'h0000_0800, 1'b1, "R6");

    // R4: overwrite by another PC at the same index
    setUpd(1'b1, 1'b1, 32'h0000_0140, 32'h0000_0A00);
    look(32'h0000_0140, 32'h0000_0144, 1'b0, "R8");
    look(32'h0000_0140, 32'h0000_0A00, 1'b1, "R4");
    look(32'h0000_0100, 32'h0000_0104, 1'b0, "R4");

    // R6: not-taken hit clears; R8 old value in the same cycle
    setUpd(1'b1, 1'b0, 32'h0000_0140, 32'h0000_0000);
    look(32'h0000_0140, 32'h0000_0A00, 1'b1, "R8");
    look(32'h0000_0140, 32'h0000_0144, 1'b0, "R6");

    // R2/R4: fill every index, then read all back
    for (int i = 0; i < (1 << IDX_W); i++) begin
      setUpd(1'b1, 1'b1, 32'h0000_1000 + 32'(4 * i), 32'h0000_2000 + 32'(16 * i));
      look(32'h0000_0000, 32'h0000_0004, 1'b0, "R3");
    end
    for (int i = 0; i < (1 << IDX_W); i++) begin
      look(32'h0000_1000 + 32'(4 * i), 32'h0000_2000 + 32'(16 * i), 1'b1, "R2");
    end

    // R5: retarget an existing entry
    setUpd(1'b1, 1'b1, 32'h0000_1004, 32'h0000_3000);
    look(32'h0000_1008, 32'h0000_2020, 1'b1, "R2");
    look(32'h0000_1004, 32'h0000_3000, 1'b1, "R5");

    // R1: reset mid-run empties the table
    @(posedge clk); #1;
    rstN = 1'b0;
    #7 rstN = 1'b1;
    look(32'h0000_1008, 32'h0000_100C, 1'b0, "R1");
    look(32'h0000_1004, 32'h0000_1008, 1'b0, "R1");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule